// File: doc/BRIEF.md
# IR Receive Run-Length Encoder

This block takes the digital output of an infrared receiver and describes it as a series of timed runs. A tick generator sets the sample rate, which is one of two rates chosen by a mode input. On every tick the block samples the polarity-corrected input line. For each stretch of constant level it produces one byte, and those bytes go into a small first-word-fall-through queue for the host to drain.

A byte holds two things: the level of the run and its length in ticks, minus one. A run that lasts longer than the length field can express is split into several bytes of the same level.

The host has a few controls around the queue. It can drop the receiver back to idle once a burst is over. It reads the overrun flag, which clears on a status-read strobe. An interrupt line combines a fill-level event and an error event, each gated by its own enable.

A second path runs beside the encoder. It counts rising edges of the raw carrier while the host allows it, so that the host can estimate the carrier frequency from the count and the summed pulse time.

Top module: `irrx_rle_top`

## Requirements
- R1: Each emitted byte has bit 7 = 1 for a space run and bit 7 = 0 for a pulse run. Bits 6:0 hold the run length in ticks minus one.
- R2: A run longer than 128 ticks is emitted as one byte of length field 0x7F for each full 128 ticks, followed by a byte carrying the remainder, all of the same level.
- R3: The tick period is PRESCALE×15 clock cycles when `fast_en` is low and PRESCALE×3 cycles when it is high. Run lengths are counted in these ticks.
- R4: After reset and after a disable, the encoder is idle. Space samples are ignored and no byte is emitted until a pulse is sampled on a tick.
- R5: A pulse on `rx_disable` returns the encoder to idle and discards the run in progress without emitting it.
- R6: The queue holds 16 bytes in first-word-fall-through order. `rx_status[0]` is 1 exactly while the queue is not empty. `rd_en` removes the head byte, and `rd_en` on an empty queue has no effect.
- R7: A byte produced while the queue is full is dropped and sets `rx_status[1]`. A `status_rd` pulse clears that flag, unless a new overrun happens in the same cycle, in which case the flag stays set.
- R8: `irq` = (`rx_irq_en` AND queue level ≥ 8) OR (`err_irq_en` AND `rx_status[1]`).
- R9: When `invert_en` is 1, a low `ir_in` is treated as pulse. When it is 0, a high `ir_in` is pulse.
- R10: The 16-bit `carrier_count` increments on each rising edge of the polarity-corrected input while `cnt_en` is 1. It holds its value while `cnt_en` is 0, goes to zero on `cnt_clr`, and saturates at 0xFFFF.
- R11: `carrier_valid` is 1 exactly when `carrier_count` is neither 0 nor 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_in | input | 1 | Raw receiver line |
| invert_en | input | 1 | Treat a low line as pulse |
| fast_en | input | 1 | Select the short tick period |
| rx_disable | input | 1 | Return the encoder to idle |
| rd_en | input | 1 | Remove the head byte of the queue |
| rd_data | output | 8 | Head byte of the queue |
| status_rd | input | 1 | Status read strobe; clears the overrun flag |
| rx_status | output | 2 | Bit 0 data available, bit 1 overrun |
| rx_irq_en | input | 1 | Enable for the fill-level interrupt |
| err_irq_en | input | 1 | Enable for the overrun interrupt |
| irq | output | 1 | Interrupt request |
| cnt_en | input | 1 | Carrier counter enable |
| cnt_clr | input | 1 | Carrier counter clear |
| carrier_count | output | 16 | Carrier rising-edge count |
| carrier_valid | output | 1 | Count is a usable reading |

## Verification
Some properties are checked on every cycle:
- the queue level stays within bounds;
- a read of an empty queue leaves the level unchanged;
- the overrun flag is sticky until a clear;
- a disable suppresses the next emission;
- every emission follows a tick;
- the carrier counter holds while disabled and is zero after a clear;
- the interrupt is gated by its enables.

Other behaviour can only be shown by the bench's scenarios, because the result is a byte sequence compared against runs of known length. This covers:
- the exact byte values, the splitting at 128 ticks and the two tick periods;
- the inversion option and idle suppression;
- the fill threshold;
- the count of carrier edges.

// File: rtl/irrx_pkg.sv
package irrx_pkg;

   typedef enum logic {
      RX_IDLE   = 1'b0,
      RX_ACTIVE = 1'b1
   } rx_state_e;

   // level 1 = pulse; byte flag bit is set for space
   function automatic logic [7:0] pack_run(input logic lvl, input logic [6:0] len_m1);
      return {~lvl, len_m1};
   endfunction

endpackage

// File: rtl/irrx_tickgen.sv
module irrx_tickgen #(
   parameter int PRESCALE = 16,
   parameter int DIV_SLOW = 15,
   parameter int DIV_FAST = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fast_en,
   output logic tick
);
   localparam int DIV_MAX = (DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST;
   localparam int TW      = $clog2(PRESCALE * DIV_MAX + 1);

   logic [TW-1:0] cnt;
   logic [TW-1:0] reload;

   assign reload = fast_en ? TW'(PRESCALE * DIV_FAST - 1) : TW'(PRESCALE * DIV_SLOW - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= TW'(PRESCALE * DIV_SLOW - 1);
         tick <= 1'b0;
      end else begin
         tick <= (cnt == '0);
         cnt  <= (cnt == '0) ? reload : cnt - 1'b1;
      end
   end
endmodule

// File: rtl/irrx_sync.sv
module irrx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ir_in,
   input  logic invert_en,
   output logic lvl
);
   logic [STAGES-1:0] chain;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= ir_in ^ invert_en;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= 1'b0;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign lvl = chain[STAGES-1];
endmodule

// File: rtl/irrx_rle_enc.sv
module irrx_rle_enc
   import irrx_pkg::*;
#(
   parameter int LEN_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             lvl,
   input  logic             rx_disable,
   output logic             push,
   output logic [LEN_W:0]   byte_out
);
   localparam logic [LEN_W-1:0] RUN_LAST = '1;

   rx_state_e        state;
   logic             cur_lvl;
   logic [LEN_W-1:0] run_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= RX_IDLE;
         cur_lvl  <= 1'b0;
         run_cnt  <= '0;
         push     <= 1'b0;
         byte_out <= '0;
      end else begin
         push <= 1'b0;
         if (rx_disable) begin
            state   <= RX_IDLE;
            run_cnt <= '0;
         end else if (tick) begin
            case (state)
               RX_IDLE: begin
                  if (lvl) begin
                     state   <= RX_ACTIVE;
                     cur_lvl <= 1'b1;
                     run_cnt <= '0;
                  end
               end
               RX_ACTIVE: begin
                  if (lvl != cur_lvl) begin
                     push     <= 1'b1;
                     byte_out <= {~cur_lvl, run_cnt};
                     cur_lvl  <= lvl;
                     run_cnt  <= '0;
                  end else if (run_cnt == RUN_LAST) begin
                     push     <= 1'b1;
                     byte_out <= {~cur_lvl, run_cnt};
                     run_cnt  <= '0;
                  end else begin
                     run_cnt <= run_cnt + 1'b1;
                  end
               end
               default: state <= RX_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/irrx_fifo.sv
module irrx_fifo #(
   parameter int DEPTH = 16,
   parameter int DW    = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       push,
   input  logic [DW-1:0]              wdata,
   input  logic                       pop,
   output logic [DW-1:0]              rdata,
   output logic [$clog2(DEPTH+1)-1:0] level,
   output logic                       empty,
   output logic                       ovf
);
   localparam int AW = $clog2(DEPTH);

   logic [DW-1:0] mem [DEPTH];
   logic [AW:0]   wr_ptr, rd_ptr;
   logic          full;
   logic          do_wr, do_rd;

   assign level = wr_ptr - rd_ptr;
   assign empty = (wr_ptr == rd_ptr);
   assign full  = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
   assign do_wr = push && !full;
   assign do_rd = pop && !empty;
   assign ovf   = push && full;
   assign rdata = mem[rd_ptr[AW-1:0]];

   always_ff @(posedge clk) begin
      if (do_wr) mem[wr_ptr[AW-1:0]] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
      end else begin
         if (do_wr) wr_ptr <= wr_ptr + 1'b1;
         if (do_rd) rd_ptr <= rd_ptr + 1'b1;
      end
   end
endmodule

// File: rtl/irrx_carrier.sv
module irrx_carrier #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lvl,
   input  logic             cnt_en,
   input  logic             cnt_clr,
   output logic [CNT_W-1:0] count,
   output logic             valid
);
   logic prev;
   logic rise;

   assign rise  = lvl && !prev;
   assign valid = (count != '0) && (count != '1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev  <= 1'b0;
         count <= '0;
      end else begin
         prev <= lvl;
         if (cnt_clr)
            count <= '0;
         else if (cnt_en && rise && (count != '1))
            count <= count + 1'b1;
      end
   end
endmodule

// File: rtl/irrx_rle_top.sv
module irrx_rle_top #(
   parameter int PRESCALE    = 16,
   parameter int DIV_SLOW    = 15,
   parameter int DIV_FAST    = 3,
   parameter int MAX_RUN     = 128,
   parameter int FIFO_DEPTH  = 16,
   parameter int RX_THRESH   = 8,
   parameter int SYNC_STAGES = 2,
   parameter int CNT_W       = 16,
   localparam int LEN_W      = $clog2(MAX_RUN),
   localparam int BYTE_W     = LEN_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ir_in,
   input  logic              invert_en,
   input  logic              fast_en,
   input  logic              rx_disable,
   input  logic              rd_en,
   output logic [BYTE_W-1:0] rd_data,
   input  logic              status_rd,
   output logic [1:0]        rx_status,
   input  logic              rx_irq_en,
   input  logic              err_irq_en,
   output logic              irq,
   input  logic              cnt_en,
   input  logic              cnt_clr,
   output logic [CNT_W-1:0]  carrier_count,
   output logic              carrier_valid
);
   localparam int LVL_W = $clog2(FIFO_DEPTH + 1);

   generate
      if ((1 << LEN_W) != MAX_RUN) begin : g_chk_run
         $error("MAX_RUN must be a power of two");
      end
      if ((1 << $clog2(FIFO_DEPTH)) != FIFO_DEPTH || FIFO_DEPTH < 2) begin : g_chk_depth
         $error("FIFO_DEPTH must be a power of two of at least 2");
      end
      if (RX_THRESH < 1 || RX_THRESH > FIFO_DEPTH) begin : g_chk_thresh
         $error("RX_THRESH out of range");
      end
      if (PRESCALE < 1 || DIV_FAST < 1 || DIV_SLOW < 1) begin : g_chk_div
         $error("tick divisors must be positive");
      end
      if (SYNC_STAGES < 1) begin : g_chk_sync
         $error("SYNC_STAGES must be positive");
      end
   endgenerate

   logic              tick;
   logic              lvl;
   logic              fifo_push;
   logic [BYTE_W-1:0] enc_byte;
   logic [LVL_W-1:0]  fifo_level;
   logic              fifo_empty;
   logic              fifo_ovf;
   logic              overrun;

   irrx_tickgen #(.PRESCALE(PRESCALE), .DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) u_tick (
      .clk(clk), .rst_n(rst_n), .fast_en(fast_en), .tick(tick));

   irrx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .invert_en(invert_en), .lvl(lvl));

   irrx_rle_enc #(.LEN_W(LEN_W)) u_enc (
      .clk(clk), .rst_n(rst_n), .tick(tick), .lvl(lvl), .rx_disable(rx_disable),
      .push(fifo_push), .byte_out(enc_byte));

   irrx_fifo #(.DEPTH(FIFO_DEPTH), .DW(BYTE_W)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(fifo_push), .wdata(enc_byte), .pop(rd_en),
      .rdata(rd_data), .level(fifo_level), .empty(fifo_empty), .ovf(fifo_ovf));

   irrx_carrier #(.CNT_W(CNT_W)) u_car (
      .clk(clk), .rst_n(rst_n), .lvl(lvl), .cnt_en(cnt_en), .cnt_clr(cnt_clr),
      .count(carrier_count), .valid(carrier_valid));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         overrun <= 1'b0;
      else if (fifo_ovf)  overrun <= 1'b1;
      else if (status_rd) overrun <= 1'b0;
   end

   assign rx_status = {overrun, !fifo_empty};
   assign irq = (rx_irq_en && (fifo_level >= LVL_W'(RX_THRESH))) || (err_irq_en && overrun);

endmodule

// File: rtl/irrx_rle_checker.sv
module irrx_rle_checker #(
   parameter int DEPTH = 16,
   parameter int LVL_W = 5,
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick,
   input logic             fifo_push,
   input logic             fifo_ovf,
   input logic             rx_disable,
   input logic             rd_en,
   input logic             status_rd,
   input logic [1:0]       rx_status,
   input logic [LVL_W-1:0] fifo_level,
   input logic             rx_irq_en,
   input logic             err_irq_en,
   input logic             irq,
   input logic             cnt_en,
   input logic             cnt_clr,
   input logic [CNT_W-1:0] carrier_count,
   input logic             carrier_valid
);
   assert_level_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_level <= LVL_W'(DEPTH));

   assert_empty_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !rx_status[0] && !fifo_push) |=> $stable(fifo_level));

   assert_ovr_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_status[1] && !status_rd) |=> rx_status[1]);

   assert_ovr_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (status_rd && !fifo_ovf) |=> !rx_status[1]);

   assert_ovr_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_ovf |=> rx_status[1]);

   assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_irq_en && !err_irq_en) |-> !irq);

   assert_disable_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rx_disable |=> !fifo_push);

   assert_push_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_push |-> $past(tick));

   assert_cnt_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_en && !cnt_clr) |=> $stable(carrier_count));

   assert_cnt_clr_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_clr |=> (carrier_count == '0));

   assert_valid_clr_R11: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_clr |=> !carrier_valid);
endmodule

bind irrx_rle_top irrx_rle_checker #(.DEPTH(FIFO_DEPTH), .LVL_W(LVL_W), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .tick(tick), .fifo_push(fifo_push), .fifo_ovf(fifo_ovf),
   .rx_disable(rx_disable), .rd_en(rd_en), .status_rd(status_rd), .rx_status(rx_status),
   .fifo_level(fifo_level), .rx_irq_en(rx_irq_en), .err_irq_en(err_irq_en), .irq(irq),
   .cnt_en(cnt_en), .cnt_clr(cnt_clr), .carrier_count(carrier_count),
   .carrier_valid(carrier_valid));

// File: tb/irrx_rle_top_tb.sv
module irrx_rle_top_tb;
   localparam int PRE = 2;
   localparam int TS  = PRE * 15;
   localparam int TF  = PRE * 3;
   localparam int NV  = 6;
   localparam int VEC [NV][2] = '{'{1, 1}, '{5, 3}, '{128, 2}, '{129, 1}, '{3, 200}, '{256, 4}};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pulse_lvl = 1'b0;
   logic        invert_en = 1'b0;
   logic        ir_in;
   logic        fast_en = 1'b0;
   logic        rx_disable = 1'b0;
   logic        rd_en = 1'b0;
   logic [7:0]  rd_data;
   logic        status_rd = 1'b0;
   logic [1:0]  rx_status;
   logic        rx_irq_en = 1'b0;
   logic        err_irq_en = 1'b0;
   logic        irq;
   logic        cnt_en = 1'b0;
   logic        cnt_clr = 1'b0;
   logic [15:0] carrier_count;
   logic        carrier_valid;

   int checks = 0;
   int failures = 0;
   logic [7:0] exp_q [$];

   always #10 clk = ~clk;
   assign ir_in = pulse_lvl ^ invert_en;

   irrx_rle_top #(.PRESCALE(PRE)) u_dut (
      .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .invert_en(invert_en), .fast_en(fast_en),
      .rx_disable(rx_disable), .rd_en(rd_en), .rd_data(rd_data), .status_rd(status_rd),
      .rx_status(rx_status), .rx_irq_en(rx_irq_en), .err_irq_en(err_irq_en), .irq(irq),
      .cnt_en(cnt_en), .cnt_clr(cnt_clr), .carrier_count(carrier_count),
      .carrier_valid(carrier_valid));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic drive(input logic lvl, input int ticks, input int per);
      pulse_lvl = lvl;
      repeat (ticks * per) @(negedge clk);
   endtask

   task automatic go_idle();
      pulse_lvl  = 1'b0;
      rx_disable = 1'b1;
      @(negedge clk);
      rx_disable = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic terminate(input int per);
      drive(1'b1, 1, per);
      repeat (4) @(negedge clk);
      go_idle();
   endtask

   task automatic add_run(input logic lvl, input int len);
      int r = len;
      while (r > 128) begin
         exp_q.push_back({~lvl, 7'h7F});
         r -= 128;
      end
      exp_q.push_back({~lvl, 7'(r - 1)});
   endtask

   task automatic pop();
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic drain_expect(input string req);
      while (exp_q.size() > 0) begin
         check(rx_status[0] == 1'b1, req, int'(rx_status[0]), 1);
         check(rd_data == exp_q[0], req, int'(rd_data), int'(exp_q[0]));
         void'(exp_q.pop_front());
         pop();
      end
      check(rx_status[0] == 1'b0, req, int'(rx_status[0]), 0);
   endtask

   task automatic flush();
      for (int k = 0; k < 40 && rx_status[0]; k++) pop();
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // reset state
      check(rx_status == 2'b00, "R6 reset status", int'(rx_status), 0);
      check(irq == 1'b0, "R8 reset irq", int'(irq), 0);
      check(carrier_count == 16'd0, "R10 reset count", int'(carrier_count), 0);
      check(carrier_valid == 1'b0, "R11 reset valid", int'(carrier_valid), 0);

      // R4: space while idle emits nothing
      drive(1'b0, 50, TS);
      check(rx_status[0] == 1'b0, "R4 idle space", int'(rx_status[0]), 0);

      // R1 R2 R3: vector table of pulse/space lengths
      for (int v = 0; v < NV; v++) begin
         drive(1'b1, VEC[v][0], TS);
         drive(1'b0, VEC[v][1], TS);
         terminate(TS);
         add_run(1'b1, VEC[v][0]);
         add_run(1'b0, VEC[v][1]);
         drain_expect("R1/R2 vector");
      end

      // R5: disable mid-run discards the partial run
      drive(1'b1, 5, TS);
      go_idle();
      repeat (3 * TS) @(negedge clk);
      check(rx_status[0] == 1'b0, "R5 discard", int'(rx_status[0]), 0);

      // R9: inverted polarity, low line is pulse
      invert_en = 1'b1;
      repeat (10) @(negedge clk);
      drive(1'b1, 4, TS);
      check(ir_in == 1'b0, "R9 line low for pulse", int'(ir_in), 0);
      drive(1'b0, 2, TS);
      terminate(TS);
      add_run(1'b1, 4);
      add_run(1'b0, 2);
      drain_expect("R9 invert");
      invert_en = 1'b0;
      repeat (10) @(negedge clk);

      // R3: short tick period
      fast_en = 1'b1;
      repeat (40) @(negedge clk);
      drive(1'b1, 10, TF);
      drive(1'b0, 3, TF);
      terminate(TF);
      add_run(1'b1, 10);
      add_run(1'b0, 3);
      drain_expect("R3 fast tick");
      fast_en = 1'b0;
      repeat (40) @(negedge clk);

      // R8 threshold, R7 overrun
      rx_irq_en = 1'b1;
      for (int w = 0; w < 8; w++) drive((w % 2) == 0, 1, TS);
      repeat (4) @(negedge clk);
      check(irq == 1'b0, "R8 below threshold", int'(irq), 0);
      drive(1'b1, 1, TS);
      repeat (4) @(negedge clk);
      check(irq == 1'b1, "R8 at threshold", int'(irq), 1);
      for (int w = 9; w < 19; w++) drive((w % 2) == 0, 1, TS);
      repeat (4) @(negedge clk);
      check(rx_status[1] == 1'b1, "R7 overrun set", int'(rx_status[1]), 1);
      rx_irq_en  = 1'b0;
      err_irq_en = 1'b1;
      #1;
      check(irq == 1'b1, "R8 error irq", int'(irq), 1);
      err_irq_en = 1'b0;
      #1;
      check(irq == 1'b0, "R8 masked", int'(irq), 0);
      go_idle();
      status_rd = 1'b1;
      @(negedge clk);
      status_rd = 1'b0;
      @(negedge clk);
      check(rx_status[1] == 1'b0, "R7 overrun cleared", int'(rx_status[1]), 0);
      check(rd_data == 8'h00, "R6 head first pulse", int'(rd_data), 0);
      pop();
      check(rd_data == 8'h80, "R6 second space", int'(rd_data), 8'h80);
      for (int k = 0; k < 15; k++) pop();
      check(rx_status[0] == 1'b0, "R6 depth 16", int'(rx_status[0]), 0);
      pop();
      check(rx_status[0] == 1'b0, "R6 empty read", int'(rx_status[0]), 0);

      // R10 R11: carrier counter
      cnt_en = 1'b1;
      for (int e = 0; e < 5; e++) begin
         pulse_lvl = 1'b1;
         repeat (2) @(negedge clk);
         pulse_lvl = 1'b0;
         repeat (2) @(negedge clk);
      end
      repeat (4) @(negedge clk);
      check(carrier_count == 16'd5, "R10 count edges", int'(carrier_count), 5);
      check(carrier_valid == 1'b1, "R11 valid", int'(carrier_valid), 1);
      cnt_en = 1'b0;
      for (int e = 0; e < 3; e++) begin
         pulse_lvl = 1'b1;
         repeat (2) @(negedge clk);
         pulse_lvl = 1'b0;
         repeat (2) @(negedge clk);
      end
      repeat (4) @(negedge clk);
      check(carrier_count == 16'd5, "R10 hold disabled", int'(carrier_count), 5);
      cnt_clr = 1'b1;
      @(negedge clk);
      cnt_clr = 1'b0;
      @(negedge clk);
      check(carrier_count == 16'd0, "R10 clear", int'(carrier_count), 0);
      check(carrier_valid == 1'b0, "R11 zero invalid", int'(carrier_valid), 0);
      go_idle();
      flush();

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule